// File: doc/BRIEF.md
# Flash Operation Sequencing Controller

This block sits on the host side of a parallel NOR flash device. It accepts a single request made of an operation type, an address, a data word and, for buffered writes, a word count. It then generates every bus cycle the operation needs, with the chip select, write strobe, read strobe and data-bus drive timed in clock cycles. The supported operations are block erase, whole-chip erase, single-word program, setting the lock bit of one block, clearing all lock bits, and a buffered multi-word program.

Every operation starts by putting the device in status mode and polling until the device reports ready. The controller then issues the command and confirm cycles for the operation and polls status again until the device is ready. It reduces the final status byte to one error code, using a fixed priority order. When that code shows a failure, the controller clears the status and returns the device to array-read mode before it reports. A one-cycle done pulse carries the result back to the host.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset, busy and done are low, and fl_ce_n, fl_we_n and fl_oe_n are high with fl_dq_oe low.
- R2: Each bus cycle holds fl_ce_n low for T_SETUP clocks before the strobe, keeps the strobe (fl_we_n for writes, fl_oe_n for reads) low for exactly T_PULSE clocks, then holds T_HOLD clocks before fl_ce_n rises. fl_dq_oe is high while fl_we_n is low, and fl_we_n and fl_oe_n are never low together.
- R3: Each accepted operation first writes 70h at the request address and then reads status repeatedly. No operation command is written until a read returns bit 7 = 1.
- R4: req_op encodings and their command pairs, all at the request address, are as follows. 0 block erase: 20h then D0h. 1 chip erase: 30h then D0h. 2 word program: 40h then req_data. 3 lock set: 60h then 01h. 4 lock clear: 60h then D0h.
- R5: After the last command cycle, the controller only reads status, with no write, until a read returns bit 7 = 1.
- R6: Buffered program (req_op 5) runs in this order. It writes E8h at the start address and reads extended status, repeating the E8h write and the read while bit 7 = 0. It then writes count-1 at the start address, writes buffer word i at start+i for i = 0..count-1, and writes D0h at the start address. The buffer word is taken from buf_word while buf_index = i.
- R7: The final status is decoded with this priority: bit 3 gives code 1 (supply), else bit 1 gives code 2 (protect), else bits 5 and 4 both set give code 3 (sequence), else bit 5 gives code 4 (erase), else bit 4 gives code 5 (program). Otherwise the code is 0.
- R8: When the code is nonzero, the controller writes 50h and then FFh at the request address before done. When the code is 0, no write follows the final status read.
- R9: done is high for exactly one clock with err_code valid. busy is high from the clock after acceptance until done.
- R10: The controller ignores a request while busy, a request with req_op 6 or 7, and a buffered request whose count is 0 or above MAX_WORDS. An ignored request produces no bus cycle and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 3 | Operation type (see R4, R6) |
| req_addr | input | AW | Block, word or start address |
| req_data | input | DW | Word for single-word program |
| req_count | input | CW | Word count for buffered program |
| buf_index | output | CW | Index of the buffer word being requested |
| buf_word | input | DW | Buffer word for the current buf_index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Decoded result, valid with done |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | DW | Data driven to the flash |
| fl_din | input | DW | Data read from the flash |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_ce_n | output | 1 | Chip select, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |

## Verification
The flash model in the bench holds busy for a chosen number of status reads, both before and after the command. A controller that sampled status only once, or that skipped the first poll, leaves a different trace of reads and writes. The same model holds extended status busy, which catches a buffered write that starts loading before the buffer is free or that does not repeat the E8h. Status bytes with several error bits set at once expose a wrong priority order, and a missing clear or array-read command shows in the trace of writes. Requests sent mid-operation, with unknown codes, or with a buffered count of zero or one above the maximum must leave the bus silent; a design that accepted them would start or restart a sequence.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        OP_BLK_ERASE  = 3'd0,
        OP_CHIP_ERASE = 3'd1,
        OP_WORD_PROG  = 3'd2,
        OP_LOCK_SET   = 3'd3,
        OP_LOCK_CLR   = 3'd4,
        OP_BUF_PROG   = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_SUPPLY   = 3'd1,
        ERR_PROTECT  = 3'd2,
        ERR_SEQUENCE = 3'd3,
        ERR_ERASE    = 3'd4,
        ERR_PROGRAM  = 3'd5
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_PRE_CMD, S_PRE_RD, S_SETUP, S_SECOND,
        S_XSR_CMD, S_XSR_RD, S_COUNT, S_BUF, S_CONFIRM,
        S_POST_RD, S_CLR, S_ARRAY, S_DONE
    } seq_state_e;

    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLRSTAT = 8'h50;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_BERASE  = 8'h20;
    localparam logic [7:0] CMD_CERASE  = 8'h30;
    localparam logic [7:0] CMD_PROG    = 8'h40;
    localparam logic [7:0] CMD_LOCK    = 8'h60;
    localparam logic [7:0] CMD_LSET    = 8'h01;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_BUFLOAD = 8'hE8;

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic [7:0] first_cmd(input op_e op);
        case (op)
            OP_BLK_ERASE:  return CMD_BERASE;
            OP_CHIP_ERASE: return CMD_CERASE;
            OP_WORD_PROG:  return CMD_PROG;
            default:       return CMD_LOCK;
        endcase
    endfunction

    function automatic logic [7:0] second_cmd(input op_e op);
        return (op == OP_LOCK_SET) ? CMD_LSET : CMD_CONFIRM;
    endfunction

endpackage

// File: rtl/flash_status_decode.sv
module flash_status_decode
    import flash_seq_pkg::*;
(
    input  logic [3:0] flags,   // {bit5, bit4, bit3, bit1} of the status byte
    output err_e       err
);
    logic b5, b4, b3, b1;
    assign {b5, b4, b3, b1} = flags;

    always_comb begin
        if (b3)            err = ERR_SUPPLY;
        else if (b1)       err = ERR_PROTECT;
        else if (b5 && b4) err = ERR_SEQUENCE;
        else if (b5)       err = ERR_ERASE;
        else if (b4)       err = ERR_PROGRAM;
        else               err = ERR_NONE;
    end
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle #(
    parameter int AW      = 22,
    parameter int DW      = 16,
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 3,
    parameter int T_HOLD  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    input  logic [DW-1:0] fl_din,
    output logic          fl_dq_oe,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int TMAX = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                              : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
    localparam int TW   = $clog2(TMAX + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_e;

    typedef struct packed {
        phase_e        phase;
        logic [TW-1:0] cnt;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          done;
        logic          ce_n;
        logic          we_n;
        logic          oe_n;
        logic          dq_oe;
    } bus_s;

    bus_s bus_d, bus_q;

    always_comb begin
        bus_d      = bus_q;
        bus_d.done = 1'b0;
        case (bus_q.phase)
            PH_IDLE: begin
                if (start) begin
                    bus_d.phase = PH_SETUP;
                    bus_d.cnt   = TW'(T_SETUP - 1);
                    bus_d.rd    = rd;
                    bus_d.addr  = addr;
                    bus_d.wdata = wdata;
                    bus_d.ce_n  = 1'b0;
                    bus_d.dq_oe = !rd;
                end
            end
            PH_SETUP: begin
                if (bus_q.cnt == '0) begin
                    bus_d.phase = PH_PULSE;
                    bus_d.cnt   = TW'(T_PULSE - 1);
                    if (bus_q.rd) bus_d.oe_n = 1'b0;
                    else          bus_d.we_n = 1'b0;
                end else begin
                    bus_d.cnt = bus_q.cnt - 1'b1;
                end
            end
            PH_PULSE: begin
                if (bus_q.cnt == '0) begin
                    bus_d.phase = PH_HOLD;
                    bus_d.cnt   = TW'(T_HOLD - 1);
                    bus_d.we_n  = 1'b1;
                    bus_d.oe_n  = 1'b1;
                    if (bus_q.rd) bus_d.rdata = fl_din;
                end else begin
                    bus_d.cnt = bus_q.cnt - 1'b1;
                end
            end
            default: begin
                if (bus_q.cnt == '0) begin
                    bus_d.phase = PH_IDLE;
                    bus_d.ce_n  = 1'b1;
                    bus_d.dq_oe = 1'b0;
                    bus_d.done  = 1'b1;
                end else begin
                    bus_d.cnt = bus_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q       <= '0;
            bus_q.phase <= PH_IDLE;
            bus_q.ce_n  <= 1'b1;
            bus_q.we_n  <= 1'b1;
            bus_q.oe_n  <= 1'b1;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign done     = bus_q.done;
    assign rdata    = bus_q.rdata;
    assign fl_addr  = bus_q.addr;
    assign fl_dout  = bus_q.wdata;
    assign fl_dq_oe = bus_q.dq_oe;
    assign fl_ce_n  = bus_q.ce_n;
    assign fl_we_n  = bus_q.we_n;
    assign fl_oe_n  = bus_q.oe_n;

    // Strobe-width monitor for the checks below
    logic          strobe;
    logic [TW:0]   stb_cnt_q;
    assign strobe = !bus_q.we_n || !bus_q.oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stb_cnt_q <= '0;
        else if (strobe) stb_cnt_q <= stb_cnt_q + 1'b1;
        else             stb_cnt_q <= '0;
    end

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));
    // R2
    strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !fl_ce_n);
    // R2
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> fl_dq_oe);
    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && stb_cnt_q != '0) |-> (stb_cnt_q == (TW+1)'(T_PULSE)));
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter  int AW        = 22,
    parameter  int DW        = 16,
    parameter  int MAX_WORDS = 16,
    parameter  int T_SETUP   = 2,
    parameter  int T_PULSE   = 3,
    parameter  int T_HOLD    = 1,
    localparam int CW        = $clog2(MAX_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [CW-1:0] req_count,
    output logic [CW-1:0] buf_index,
    input  logic [DW-1:0] buf_word,
    output logic          busy,
    output logic          done,
    output logic [2:0]    err_code,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    input  logic [DW-1:0] fl_din,
    output logic          fl_dq_oe,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    typedef struct packed {
        seq_state_e    state;
        logic          launch;
        op_e           op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [CW-1:0] count;
        logic [CW-1:0] idx;
        err_e          err;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic          bus_rd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_done;
    logic [DW-1:0] bus_rdata;
    err_e          dec_err;
    logic          req_ok;
    logic          ready_bit;
    logic [CW-1:0] idx_next;
    logic          unused_bits;

    assign ready_bit   = bus_rdata[7];
    assign unused_bits = ^{bus_rdata[DW-1:8], bus_rdata[6], bus_rdata[2], bus_rdata[0]};
    assign idx_next    = ctl_q.idx + 1'b1;
    assign req_ok      = op_known(req_op) &&
                         ((req_op != OP_BUF_PROG) ||
                          (req_count != '0 && req_count <= CW'(MAX_WORDS)));

    flash_status_decode u_dec (
        .flags ({bus_rdata[5], bus_rdata[4], bus_rdata[3], bus_rdata[1]}),
        .err   (dec_err)
    );

    flash_bus_cycle #(
        .AW(AW), .DW(DW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ctl_q.launch),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .done     (bus_done),
        .rdata    (bus_rdata),
        .fl_addr  (fl_addr),
        .fl_dout  (fl_dout),
        .fl_din   (fl_din),
        .fl_dq_oe (fl_dq_oe),
        .fl_ce_n  (fl_ce_n),
        .fl_we_n  (fl_we_n),
        .fl_oe_n  (fl_oe_n)
    );

    // Bus cycle contents per state
    always_comb begin
        bus_rd    = 1'b0;
        bus_addr  = ctl_q.addr;
        bus_wdata = DW'(CMD_STATUS);
        case (ctl_q.state)
            S_PRE_RD, S_XSR_RD, S_POST_RD: bus_rd = 1'b1;
            S_SETUP:   bus_wdata = DW'(first_cmd(ctl_q.op));
            S_SECOND:  bus_wdata = (ctl_q.op == OP_WORD_PROG) ? ctl_q.data
                                                              : DW'(second_cmd(ctl_q.op));
            S_XSR_CMD: bus_wdata = DW'(CMD_BUFLOAD);
            S_COUNT:   bus_wdata = DW'(ctl_q.count) - DW'(1);
            S_BUF: begin
                bus_addr  = ctl_q.addr + AW'(ctl_q.idx);
                bus_wdata = buf_word;
            end
            S_CONFIRM: bus_wdata = DW'(CMD_CONFIRM);
            S_CLR:     bus_wdata = DW'(CMD_CLRSTAT);
            S_ARRAY:   bus_wdata = DW'(CMD_ARRAY);
            default:   bus_wdata = DW'(CMD_STATUS);
        endcase
    end

    // Sequencing
    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.launch = 1'b0;
        case (ctl_q.state)
            S_IDLE: begin
                if (req_valid && req_ok) begin
                    ctl_d.state  = S_PRE_CMD;
                    ctl_d.launch = 1'b1;
                    ctl_d.op     = op_e'(req_op);
                    ctl_d.addr   = req_addr;
                    ctl_d.data   = req_data;
                    ctl_d.count  = req_count;
                    ctl_d.idx    = '0;
                    ctl_d.err    = ERR_NONE;
                end
            end
            S_PRE_CMD: if (bus_done) begin
                ctl_d.state  = S_PRE_RD;
                ctl_d.launch = 1'b1;
            end
            S_PRE_RD: if (bus_done) begin
                ctl_d.launch = 1'b1;
                if (ready_bit)
                    ctl_d.state = (ctl_q.op == OP_BUF_PROG) ? S_XSR_CMD : S_SETUP;
            end
            S_SETUP: if (bus_done) begin
                ctl_d.state  = S_SECOND;
                ctl_d.launch = 1'b1;
            end
            S_SECOND: if (bus_done) begin
                ctl_d.state  = S_POST_RD;
                ctl_d.launch = 1'b1;
            end
            S_XSR_CMD: if (bus_done) begin
                ctl_d.state  = S_XSR_RD;
                ctl_d.launch = 1'b1;
            end
            S_XSR_RD: if (bus_done) begin
                ctl_d.state  = ready_bit ? S_COUNT : S_XSR_CMD;
                ctl_d.launch = 1'b1;
            end
            S_COUNT: if (bus_done) begin
                ctl_d.state  = S_BUF;
                ctl_d.idx    = '0;
                ctl_d.launch = 1'b1;
            end
            S_BUF: if (bus_done) begin
                ctl_d.launch = 1'b1;
                if (idx_next == ctl_q.count) ctl_d.state = S_CONFIRM;
                else                         ctl_d.idx   = idx_next;
            end
            S_CONFIRM: if (bus_done) begin
                ctl_d.state  = S_POST_RD;
                ctl_d.launch = 1'b1;
            end
            S_POST_RD: if (bus_done) begin
                if (ready_bit) begin
                    ctl_d.err = dec_err;
                    if (dec_err != ERR_NONE) begin
                        ctl_d.state  = S_CLR;
                        ctl_d.launch = 1'b1;
                    end else begin
                        ctl_d.state = S_DONE;
                    end
                end else begin
                    ctl_d.launch = 1'b1;
                end
            end
            S_CLR: if (bus_done) begin
                ctl_d.state  = S_ARRAY;
                ctl_d.launch = 1'b1;
            end
            S_ARRAY: if (bus_done) ctl_d.state = S_DONE;
            default: ctl_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= S_IDLE;
            ctl_q.op    <= OP_BLK_ERASE;
            ctl_q.err   <= ERR_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = ctl_q.state != S_IDLE;
    assign done      = ctl_q.state == S_DONE;
    assign err_code  = ctl_q.err;
    assign buf_index = ctl_q.idx;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> fl_ce_n);
    // R10
    accept_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    // R5
    post_poll_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == S_POST_RD) |-> fl_we_n);
    // R8
    err_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != ERR_NONE) |-> ($past(ctl_q.state) == S_ARRAY));
endmodule

// File: tb/sim_flash_seq_ctrl.sv
module sim_flash_seq_ctrl;
    localparam int AW = 22, DW = 16, MAXW = 16, CW = 5;
    localparam int TS = 2, TP = 3, TH = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [CW-1:0] req_count = '0;
    logic [CW-1:0] buf_index;
    logic [DW-1:0] buf_word;
    logic busy, done, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;
    logic [2:0]    err_code;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dout, fl_din;

    flash_seq_ctrl #(.AW(AW), .DW(DW), .MAX_WORDS(MAXW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .req_count(req_count), .buf_index(buf_index), .buf_word(buf_word),
        .busy(busy), .done(done), .err_code(err_code), .fl_addr(fl_addr), .fl_dout(fl_dout),
        .fl_din(fl_din), .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

    assign buf_word = 16'hA000 + DW'(buf_index);

    int tests = 0, fails = 0;
    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic mon_en = 1'b0;
    int   m_mode = 0;          // 0 array, 1 status, 2 extended status
    int   m_busy = 0, m_post = 0, m_xsr = 0, m_arm = 0, m_left = 0;
    logic [7:0] m_last = '0, m_inject = '0, m_sr = '0;
    logic          lk [64];
    logic [AW-1:0] la [64];
    logic [DW-1:0] ld [64];
    int   log_n = 0;
    logic          ek [64];
    logic [AW-1:0] ea [64];
    logic [DW-1:0] ed [64];
    int   exp_n = 0;

    assign fl_din = (m_mode == 1) ? {8'h00, (m_busy == 0), 1'b0, m_sr[5:0]} :
                    (m_mode == 2) ? {8'h00, (m_xsr == 0), 7'b0} : 16'h1234;

    task automatic confirm_op();
        m_mode = 1; m_busy = m_post; m_sr = m_inject & 8'h3A;
    endtask

    always @(posedge fl_we_n) if (mon_en && !fl_ce_n) begin
        if (log_n < 64) begin lk[log_n] = 1'b0; la[log_n] = fl_addr; ld[log_n] = fl_dout; end
        log_n++;
        if (m_arm == 1) begin confirm_op(); m_arm = 0; end
        else if (m_arm == 2) begin m_left = int'(fl_dout) + 1; m_arm = 3; end
        else if (m_arm == 3) begin m_left--; if (m_left == 0) m_arm = 4; end
        else if (m_arm == 4) begin if (fl_dout[7:0] == 8'hD0) confirm_op(); m_arm = 0; end
        else begin
            case (fl_dout[7:0])
                8'h70: m_mode = 1;
                8'h50: m_sr = '0;
                8'hFF: m_mode = 0;
                8'h40: m_arm = 1;
                8'hE8: begin m_mode = 2; if (m_xsr == 0) m_arm = 2; end
                8'h20, 8'h30, 8'h60: m_last = fl_dout[7:0];
                8'hD0, 8'h01: if (m_last != 0) begin confirm_op(); m_last = 0; end
                default: ;
            endcase
        end
    end

    always @(posedge fl_oe_n) if (mon_en && !fl_ce_n) begin
        if (log_n < 64) begin lk[log_n] = 1'b1; la[log_n] = fl_addr; ld[log_n] = '0; end
        log_n++;
        if (m_mode == 1 && m_busy > 0) m_busy--;
        if (m_mode == 2 && m_xsr > 0) m_xsr--;
    end

    // ---------------- timing / pulse monitors ----------------
    int run = 0, sw = 0, pre = 0, nbus = 0, tbad = 0, both_low = 0, drive_bad = 0;
    int drun = 0, dbad = 0;
    always @(negedge clk) if (mon_en) begin
        if (!fl_we_n && !fl_oe_n) both_low++;
        if (!fl_we_n && !fl_dq_oe) drive_bad++;
        if (!fl_ce_n) begin
            run++;
            if (!fl_we_n || !fl_oe_n) sw++;
            else if (sw == 0) pre++;
        end else begin
            if (run != 0) begin
                nbus++;
                if (run != TS + TP + TH || sw != TP || pre != TS) tbad++;
            end
            run = 0; sw = 0; pre = 0;
        end
        if (done) drun++;
        else begin if (drun != 0 && drun != 1) dbad++; drun = 0; end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- expected trace helpers ----------------
    task automatic push(input logic k, input logic [AW-1:0] a, input logic [DW-1:0] d);
        ek[exp_n] = k; ea[exp_n] = a; ed[exp_n] = d; exp_n++;
    endtask

    task automatic build_exp(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] dat,
                             input int cnt, input int pr, input int po, input int xs, input logic err_path);
        exp_n = 0;
        push(0, a, 16'h0070);
        for (int i = 0; i <= pr; i++) push(1, a, 0);
        case (op)
            3'd0: begin push(0, a, 16'h0020); push(0, a, 16'h00D0); end
            3'd1: begin push(0, a, 16'h0030); push(0, a, 16'h00D0); end
            3'd2: begin push(0, a, 16'h0040); push(0, a, dat); end
            3'd3: begin push(0, a, 16'h0060); push(0, a, 16'h0001); end
            3'd4: begin push(0, a, 16'h0060); push(0, a, 16'h00D0); end
            default: begin
                for (int i = 0; i <= xs; i++) begin push(0, a, 16'h00E8); push(1, a, 0); end
                push(0, a, DW'(cnt - 1));
                for (int i = 0; i < cnt; i++) push(0, a + AW'(i), 16'hA000 + DW'(i));
                push(0, a, 16'h00D0);
            end
        endcase
        for (int i = 0; i <= po; i++) push(1, a, 0);
        if (err_path) begin push(0, a, 16'h0050); push(0, a, 16'h00FF); end
    endtask

    task automatic cmp_log(input string tag);
        int bad = -1;
        if (log_n != exp_n) begin
            chk(0, {tag, " trace length"}, log_n, exp_n);
            return;
        end
        for (int i = 0; i < exp_n; i++)
            if (bad < 0 && (lk[i] !== ek[i] || la[i] !== ea[i] || (!ek[i] && ld[i] !== ed[i]))) bad = i;
        if (bad >= 0) chk(0, {tag, " trace entry"}, {lk[bad], la[bad], ld[bad]}, {ek[bad], ea[bad], ed[bad]});
        else          chk(1, tag, 0, 0);
    endtask

    task automatic do_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] dat,
                         input int cnt, input int pr, input int po, input int xs,
                         input logic [7:0] inj, output logic [2:0] err);
        m_busy = pr; m_post = po; m_xsr = xs; m_inject = inj; m_arm = 0; m_last = '0;
        m_mode = 0; m_sr = '0; log_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = dat; req_count = CW'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R9 busy after accept", busy, 1);
        for (int i = 0; i < 5000 && done !== 1'b1; i++) @(negedge clk);
        chk(done === 1'b1, "R9 done seen", done, 1);
        err = err_code;
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R9 single done then idle", {done, busy}, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(busy === 0 && done === 0, "R1 busy/done low", {busy, done}, 0);
        chk(fl_ce_n === 1 && fl_we_n === 1 && fl_oe_n === 1 && fl_dq_oe === 0,
            "R1 bus idle", {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
    endtask

    task automatic t_block_erase();
        logic [2:0] e;
        do_op(3'd0, 22'h0A1234, 0, 0, 2, 3, 0, 8'h00, e);
        build_exp(3'd0, 22'h0A1234, 0, 0, 2, 3, 0, 0);
        cmp_log("R3 R4 R5 block erase trace");
        chk(e == 3'd0, "R7 block erase ok", e, 0);
    endtask

    task automatic t_other_ops();
        logic [2:0] e;
        do_op(3'd1, 22'h000010, 0, 0, 0, 1, 0, 8'h00, e);
        build_exp(3'd1, 22'h000010, 0, 0, 0, 1, 0, 0);
        cmp_log("R4 chip erase trace");
        do_op(3'd2, 22'h1F0002, 16'h5AC3, 0, 1, 0, 0, 8'h00, e);
        build_exp(3'd2, 22'h1F0002, 16'h5AC3, 0, 1, 0, 0, 0);
        cmp_log("R4 word program trace");
        do_op(3'd3, 22'h230000, 0, 0, 0, 2, 0, 8'h00, e);
        build_exp(3'd3, 22'h230000, 0, 0, 0, 2, 0, 0);
        cmp_log("R4 lock set trace");
        do_op(3'd4, 22'h000000, 0, 0, 0, 0, 0, 8'h00, e);
        build_exp(3'd4, 22'h000000, 0, 0, 0, 0, 0, 0);
        cmp_log("R4 lock clear trace");
        chk(e == 3'd0, "R7 lock clear ok", e, 0);
    endtask

    task automatic t_buffer();
        logic [2:0] e;
        do_op(3'd5, 22'h004000, 0, 3, 1, 2, 2, 8'h00, e);
        build_exp(3'd5, 22'h004000, 0, 3, 1, 2, 2, 0);
        cmp_log("R6 buffered write 3 words, busy buffer");
        do_op(3'd5, 22'h0080F0, 0, MAXW, 0, 0, 0, 8'h00, e);
        build_exp(3'd5, 22'h0080F0, 0, MAXW, 0, 0, 0, 0);
        cmp_log("R6 buffered write max count");
        do_op(3'd5, 22'h000100, 0, 1, 0, 1, 1, 8'h10, e);
        build_exp(3'd5, 22'h000100, 0, 1, 0, 1, 1, 1);
        cmp_log("R6 R8 buffered write single word with error");
        chk(e == 3'd5, "R7 buffered program error", e, 5);
    endtask

    task automatic t_errors();
        logic [7:0] masks [6] = '{8'h3A, 8'h32, 8'h30, 8'h20, 8'h10, 8'h08};
        logic [2:0] codes [6] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd1};
        logic [2:0] e;
        for (int i = 0; i < 6; i++) begin
            do_op(3'd0, 22'h050000, 0, 0, 0, 1, 0, masks[i], e);
            chk(e == codes[i], "R7 error priority", e, codes[i]);
            build_exp(3'd0, 22'h050000, 0, 0, 0, 1, 0, 1);
            cmp_log("R8 clear and array-read after error");
        end
    endtask

    task automatic t_busy_ignore();
        logic [2:0] e;
        int n0;
        m_busy = 0; m_post = 20; m_xsr = 0; m_inject = 0; m_arm = 0; m_last = '0;
        m_mode = 0; m_sr = '0; log_n = 0;
        @(negedge clk);
        req_valid = 1; req_op = 3'd0; req_addr = 22'h012345; req_count = 0;
        @(negedge clk);
        req_valid = 0;
        repeat (40) @(negedge clk);
        req_valid = 1; req_op = 3'd1; req_addr = 22'h3FFFFF;
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < 5000 && done !== 1'b1; i++) @(negedge clk);
        e = err_code;
        build_exp(3'd0, 22'h012345, 0, 0, 0, 20, 0, 0);
        cmp_log("R10 request while busy ignored");
        chk(e == 0, "R7 no error after ignored request", e, 0);
        n0 = log_n;
        repeat (60) @(negedge clk);
        chk(log_n == n0 && busy === 0, "R10 no restart after busy request", log_n, n0);
    endtask

    task automatic t_bad_requests();
        logic [2:0] bad_ops [2] = '{3'd6, 3'd7};
        for (int i = 0; i < 2; i++) begin
            log_n = 0;
            @(negedge clk); req_valid = 1; req_op = bad_ops[i];
            @(negedge clk); req_valid = 0;
            repeat (30) @(negedge clk);
            chk(log_n == 0 && busy === 0 && done === 0, "R10 unknown op ignored", log_n, 0);
        end
        log_n = 0;
        @(negedge clk); req_valid = 1; req_op = 3'd5; req_count = 0;
        @(negedge clk); req_valid = 0;
        repeat (30) @(negedge clk);
        chk(log_n == 0 && busy === 0, "R10 buffered count zero ignored", log_n, 0);
        log_n = 0;
        @(negedge clk); req_valid = 1; req_op = 3'd5; req_count = CW'(MAXW + 1);
        @(negedge clk); req_valid = 0;
        repeat (30) @(negedge clk);
        chk(log_n == 0 && busy === 0, "R10 buffered count above max ignored", log_n, 0);
    endtask

    task automatic t_timing();
        chk(nbus > 0 && tbad == 0, "R2 setup/pulse/hold cycle counts", tbad, 0);
        chk(both_low == 0, "R2 strobes exclusive", both_low, 0);
        chk(drive_bad == 0, "R2 data driven during write strobe", drive_bad, 0);
        chk(dbad == 0, "R9 done width one cycle", dbad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        t_reset();
        t_block_erase();
        t_other_ops();
        t_buffer();
        t_errors();
        t_busy_ignore();
        t_bad_requests();
        t_timing();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule